// File: doc/BRIEF.md
# Selectable Register Bank with All-Zero Flag

This block stores a word of configurable width. On each rising clock edge every bit position loads one of two candidate input words. A single shared select line picks which word. The stored word is driven straight out. A status output reports when every stored bit is zero.

Typical use is as a pipeline register that chooses between two sources. The zero flag then serves as a cheap "result is zero" indicator, and it lines up cycle for cycle with the stored data. Reset is synchronous and active high. It clears the whole word, which asserts the flag.

Top module: `mux_reg_bank`

## Requirements
- R1: The word width is the parameter WIDTH, whose default is 8.
- R2: On a rising clock edge with rst low and sel = 0, every bit q[i] loads a_in[i].
- R3: On a rising clock edge with rst low and sel = 1, every bit q[i] loads b_in[i].
- R4: The input word that sel does not choose has no effect on the stored value.
- R5: When rst is high at a rising clock edge, q becomes all zeros and all_zero becomes 1, regardless of sel, a_in and b_in.
- R6: all_zero is 1 exactly when every bit of q is 0. It changes in the same cycle as q, with no added register delay.
- R7: q keeps its value between rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Word loaded when sel = 0 |
| b_in | input | WIDTH | Word loaded when sel = 1 |
| sel | input | 1 | Shared source select |
| q | output | WIDTH | Stored word |
| all_zero | output | 1 | High when q is all zeros |

## Verification
A slice that captures from the wrong source shows up on q one edge after the load. This is most visible when a_in and b_in are bitwise complements. A flag decoded from the wrong bits, or through an extra stage, would disagree with q in the first cycle after the word changes to or from zero. The bench therefore checks q and all_zero together right after every edge. It also includes single-bit words at the MSB and the LSB, where a flag that misses an end bit would stay high.

// File: rtl/mux_reg_bank.sv
module mux_reg_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             sel,
  output logic [WIDTH-1:0] q,
  output logic             all_zero
);

  logic [WIDTH-1:0] d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign d[i] = sel ? b_in[i] : a_in[i];

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end

  assign all_zero = ~|q;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  a_r2_load_a: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (past_ok && q == $past(a_in)));

  a_r3_load_b: assert property (@(posedge clk) disable iff (rst)
    sel |=> (q == $past(b_in)));

  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (q == '0 && all_zero));

  a_r6_flag_matches: assert property (@(posedge clk) disable iff (rst)
    all_zero == (q == '0));

  a_r6_flag_rises: assert property (@(posedge clk) disable iff (rst)
    $rose(all_zero) |-> $past(q) != '0);

endmodule

// File: tb/mux_reg_bank_test.sv
module mux_reg_bank_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in;
  logic sel;
  logic [W-1:0] q;
  logic all_zero;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mux_reg_bank #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .sel(sel),
    .q(q), .all_zero(all_zero)
  );

  task automatic check(input string req, input logic [W-1:0] exp_q);
    logic exp_z;
    exp_z = (exp_q == '0);
    checks++;
    if (q !== exp_q || all_zero !== exp_z) begin
      errors++;
      $display("FAIL %s: q=%h zero=%b expected q=%h zero=%b", req, q, all_zero, exp_q, exp_z);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    rst = r; sel = s; a_in = a; b_in = b;
    @(posedge clk); #2;
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, 8'hFF, 8'hA5);
    check("R5", 8'h00);
    step(1'b1, 1'b0, 8'h3C, 8'hFF);
    check("R5", 8'h00);
  endtask

  task automatic t_load_a;
    step(1'b0, 1'b0, 8'h5A, 8'hA5);
    check("R2", 8'h5A);
    step(1'b0, 1'b0, 8'h80, 8'hFF);
    check("R2 msb", 8'h80);
    step(1'b0, 1'b0, 8'h01, 8'hFF);
    check("R2 lsb", 8'h01);
  endtask

  task automatic t_load_b;
    step(1'b0, 1'b1, 8'hA5, 8'h5A);
    check("R3", 8'h5A);
    step(1'b0, 1'b1, 8'h00, 8'hC3);
    check("R3", 8'hC3);
  endtask

  task automatic t_ignore;
    step(1'b0, 1'b1, 8'hFF, 8'h00);
    check("R4 a ignored", 8'h00);
    step(1'b0, 1'b0, 8'h00, 8'hFF);
    check("R4 b ignored", 8'h00);
  endtask

  task automatic t_flag;
    step(1'b0, 1'b0, 8'h10, 8'h00);
    check("R6 leave zero", 8'h10);
    step(1'b0, 1'b1, 8'h10, 8'h00);
    check("R6 to zero", 8'h00);
    step(1'b0, 1'b0, 8'hFF, 8'h00);
    check("R6", 8'hFF);
  endtask

  task automatic t_hold;
    logic [W-1:0] held;
    held = q;
    @(negedge clk);
    a_in = 8'h00; b_in = 8'h00; sel = 1'b1;
    #1;
    check("R7 hold", held);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] a, b;
      a = W'(i * 37 + 11);
      b = W'(i * 91 + 5);
      step(1'b0, i[0], a, b);
      check("R1 width", i[0] ? b : a);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sel = 1'b0; a_in = '0; b_in = '0;
    t_reset();
    t_load_a();
    t_load_b();
    t_ignore();
    t_flag();
    t_hold();
    t_reset();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule